// File: doc/BRIEF.md
# I2C Master STOP Sequencer with Stretch-Aware Bus Timer

This block owns the two open-drain lines of an I2C master for the closing part of a transfer. Once the acknowledge clock has ended and the master is holding SCL low, a host request makes the block emit a STOP condition in three equal, timed steps. First SDA is pulled low. Then SCL is let go. Finally SDA is let go. Each step lasts one bus period, and that period is a whole number of machine cycles taken from a 7-bit reload value. When the sequence ends, the block clears the host's request bit, sets a sticky status bit and emits a one-cycle interrupt pulse.

The period timer counts only on machine-cycle ticks, and one tick comes every four clocks. Both bus lines are read through two-flop synchronizers. After SCL is let go, the timer does not run until the synchronized SCL is seen high. A slave that holds SCL low therefore stretches the sequence, and the high time is measured from the real rising edge rather than from the moment SCL was released. The same wait-then-measure rule applies to the last step: the final period starts only after SDA is seen high.

The state machine has these states. `ST_OFF` means both lines are released. `ST_HOLD` means SCL is held low after the acknowledge clock. `ST_SDA_LOW` times the SDA low set-up. `ST_SCL_REL` waits with SCL released for it to read high. `ST_SCL_HIGH` times the SCL high interval. `ST_SDA_REL` waits with SDA released for it to read high. `ST_STOP_HOLD` times the final period.

The transitions are as follows:
- `ST_OFF`→`ST_HOLD` on `ack_fall`.
- `ST_HOLD`→`ST_SDA_LOW` on a tick with the request set.
- `ST_SDA_LOW`→`ST_SCL_REL` on timer expiry.
- `ST_SCL_REL`→`ST_SCL_HIGH` on a tick that sees SCL high.
- `ST_SCL_HIGH`→`ST_SDA_REL` on expiry.
- `ST_SDA_REL`→`ST_STOP_HOLD` on a tick that sees SDA high.
- `ST_STOP_HOLD`→`ST_OFF` on expiry, which is the completion event.

Top module: `i2c_stop_engine`

## Requirements
- R1: After reset both line enables are low, the request bit `stop_en` is 0, `stop_done` is 0 and `stop_irq` is 0.
- R2: One bus period equals N machine cycles, where N is the reload value `brg_reload` and one machine cycle is 4 clocks. SDA is driven low while SCL is still driven low, and SCL is released exactly 4·N clocks after SDA was driven low.
- R3: A reload value of 0 behaves as N = 1, so the SDA low set-up lasts 4 clocks.
- R4: While SCL is released but held low by another device, the timer is frozen and SDA stays driven low. Counting starts on the first tick that sees the synchronized SCL high. SDA is released between 4·N+3 and 4·N+6 clocks after the line actually rises.
- R5: With no stretching, SDA is released exactly 4·N+4 clocks after SCL is released. This is one tick to observe the rise plus one bus period.
- R6: Exactly 4·N+4 clocks after SDA is released, `stop_done` is set, `stop_en` is cleared and `stop_irq` is high for exactly one clock.
- R7: `stop_done` stays set until `op_start` is pulsed, and it clears on the clock after that pulse.
- R8: A `stop_set` pulse received in `ST_OFF` leaves both lines released and `stop_en` set. The pending request is launched once `ack_fall` moves the block into `ST_HOLD`. SDA is only ever driven low while SCL is already driven low.
- R9: Asserting `rst_n` during a sequence aborts it at once: both lines are released and `stop_en` is cleared.
- R10: SDA is released only while SCL is released, so the only SDA rising edge the block makes is a STOP condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brg_reload | input | 7 | Bus period length in machine cycles (0 acts as 1) |
| stop_set | input | 1 | Host write pulse that sets the request bit |
| op_start | input | 1 | Host pulse for a new bus operation; clears `stop_done` |
| ack_fall | input | 1 | Pulse marking the falling edge of the acknowledge clock |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| stop_en | output | 1 | Request bit, cleared by hardware on completion |
| stop_done | output | 1 | Sticky STOP-completed status |
| stop_irq | output | 1 | One-clock completion pulse |

## Verification
The hardest condition to reach is a frozen timer, where SCL has been released but another device still holds it low. From the ports this is indistinguishable from a slow line. The bench models the bus as a wired-AND with a slave hold term. It asserts that term before the request, keeps it for a stretch that is longer than several bus periods, and confirms that SDA is still driven low throughout. It then times SDA's release against the actual rising edge of the line, not against the release of SCL.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_HOLD,
        ST_SDA_LOW,
        ST_SCL_REL,
        ST_SCL_HIGH,
        ST_SDA_REL,
        ST_STOP_HOLD
    } stop_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cycle_tick.sv
module i2c_cycle_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);
endmodule

// File: rtl/i2c_baud_timer.sv
module i2c_baud_timer #(
    parameter int RW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [RW-1:0] reload,
    output logic          expire
);
    localparam logic [RW-1:0] ONE = RW'(1);

    logic [RW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      remain <= '0;
        else if (load)                   remain <= (reload == '0) ? ONE : reload;
        else if (tick && remain != '0)   remain <= remain - 1'b1;
    end

    assign expire = tick && !load && (remain == ONE);
endmodule

// File: rtl/i2c_stop_engine.sv
module i2c_stop_engine
    import i2c_stop_pkg::*;
#(
    parameter int RELOAD_W    = 7,
    parameter int CYCLE_DIV   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RELOAD_W-1:0] brg_reload,
    input  logic                stop_set,
    input  logic                op_start,
    input  logic                ack_fall,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                scl_oe,
    output logic                sda_oe,
    output logic                stop_en,
    output logic                stop_done,
    output logic                stop_irq
);
    stop_state_e st, nxt;
    logic tick, expire, tmr_load, done_evt;
    logic scl_s, sda_s;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

    i2c_cycle_tick #(.DIV(CYCLE_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    i2c_baud_timer #(.RW(RELOAD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(tmr_load),
        .reload(brg_reload), .expire(expire));

    // next-state and timer control
    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        done_evt = 1'b0;
        unique case (st)
            ST_OFF:       if (ack_fall) nxt = ST_HOLD;
            ST_HOLD:      if (tick && stop_en) begin
                              nxt = ST_SDA_LOW;
                              tmr_load = 1'b1;
                          end
            ST_SDA_LOW:   if (expire) nxt = ST_SCL_REL;
            ST_SCL_REL:   if (tick && scl_s) begin
                              nxt = ST_SCL_HIGH;
                              tmr_load = 1'b1;
                          end
            ST_SCL_HIGH:  if (expire) nxt = ST_SDA_REL;
            ST_SDA_REL:   if (tick && sda_s) begin
                              nxt = ST_STOP_HOLD;
                              tmr_load = 1'b1;
                          end
            ST_STOP_HOLD: if (expire) begin
                              nxt = ST_OFF;
                              done_evt = 1'b1;
                          end
            default:      nxt = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= nxt;
    end

    // line drive follows the state
    always_comb begin
        scl_oe = (st == ST_HOLD) || (st == ST_SDA_LOW);
        sda_oe = (st == ST_SDA_LOW) || (st == ST_SCL_REL) || (st == ST_SCL_HIGH);
    end

    // host-visible flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_en   <= 1'b0;
            stop_done <= 1'b0;
            stop_irq  <= 1'b0;
        end else begin
            stop_irq <= done_evt;
            if (done_evt)      stop_en <= 1'b0;
            else if (stop_set) stop_en <= 1'b1;
            if (done_evt)      stop_done <= 1'b1;
            else if (op_start) stop_done <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_stop_engine_chk.sv
module i2c_stop_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_set,
    input logic op_start,
    input logic scl_in,
    input logic scl_oe,
    input logic sda_oe,
    input logic stop_en,
    input logic stop_done,
    input logic stop_irq
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!scl_oe && !sda_oe && !stop_en && !stop_done && !stop_irq));

    a_r2_scl_release_after_sda: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> sda_oe);

    a_r4_frozen_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && sda_oe && !scl_in) |=> sda_oe);

    a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |=> !stop_irq);

    a_r6_done_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_done) |-> (!stop_en && stop_irq));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_done && !op_start) |=> stop_done);

    a_r8_sda_low_under_scl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (scl_oe && $past(scl_oe)));

    a_r8_req_from_host: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_en) |-> $past(stop_set));

    a_r10_stop_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_oe);
endmodule

bind i2c_stop_engine i2c_stop_engine_chk u_chk (.*);

// File: tb/tb_i2c_stop_engine.sv
module tb_i2c_stop_engine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] brg_reload = 7'd5;
    logic       stop_set = 1'b0, op_start = 1'b0, ack_fall = 1'b0;
    logic       slv_hold = 1'b0;
    logic       scl_in, sda_in, scl_oe, sda_oe, stop_en, stop_done, stop_irq;
    int         cyc = 0;
    int         checks = 0, failures = 0;
    bit         finished = 1'b0;

    assign scl_in = !(scl_oe || slv_hold);
    assign sda_in = !sda_oe;

    i2c_stop_engine dut (
        .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload),
        .stop_set(stop_set), .op_start(op_start), .ack_fall(ack_fall),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .stop_en(stop_en), .stop_done(stop_done), .stop_irq(stop_irq));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: stop_set = 1'b1;
            1: op_start = 1'b1;
            default: ack_fall = 1'b1;
        endcase
        @(negedge clk);
        stop_set = 1'b0; op_start = 1'b0; ack_fall = 1'b0;
    endtask

    // which: 0 sda_oe, 1 scl_oe, 2 stop_irq; returns cyc at first match
    task automatic wait_sig(input int which, input logic val, output int t);
        logic v;
        t = -1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            case (which)
                0: v = sda_oe;
                1: v = scl_oe;
                default: v = stop_irq;
            endcase
            if (v == val) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_reset_state();
        do_reset();
        check(!scl_oe && !sda_oe, "R1", {scl_oe, sda_oe}, 0);
        check(!stop_en && !stop_done && !stop_irq, "R1", {stop_en, stop_done, stop_irq}, 0);
    endtask

    task automatic run_stop(input logic [6:0] rl, input int stretch, input bit pre_req);
        int n, t0, t1, tr, t2, t3;
        n = (rl == 0) ? 1 : int'(rl);
        brg_reload = rl;
        pulse(1);
        check(!stop_done, "R7", stop_done, 0);
        if (stretch > 0) slv_hold = 1'b1;
        if (pre_req) begin
            pulse(0);
            repeat (20) @(negedge clk);
            check(!scl_oe && !sda_oe && stop_en, "R8", {scl_oe, sda_oe, stop_en}, 1);
            pulse(2);
        end else begin
            pulse(2);
            check(scl_oe && !sda_oe, "R8", {scl_oe, sda_oe}, 2);
            pulse(0);
        end
        wait_sig(0, 1'b1, t0);
        check(scl_oe, "R8", scl_oe, 1);
        wait_sig(1, 1'b0, t1);
        check(t1 - t0 == 4*n, (rl == 0) ? "R3" : "R2", t1 - t0, 4*n);
        if (stretch > 0) begin
            repeat (stretch) @(negedge clk);
            check(sda_oe && !scl_oe, "R4", {scl_oe, sda_oe}, 1);
            slv_hold = 1'b0;
            tr = cyc;
            wait_sig(0, 1'b0, t2);
            check((t2 - tr >= 4*n + 3) && (t2 - tr <= 4*n + 6), "R4", t2 - tr, 4*n + 3);
        end else begin
            wait_sig(0, 1'b0, t2);
            check(t2 - t1 == 4*n + 4, "R5", t2 - t1, 4*n + 4);
        end
        check(!scl_oe, "R10", scl_oe, 0);
        wait_sig(2, 1'b1, t3);
        check(t3 - t2 == 4*n + 4, "R6", t3 - t2, 4*n + 4);
        check(stop_done && !stop_en, "R6", {stop_done, stop_en}, 2);
        @(negedge clk);
        check(!stop_irq, "R6", stop_irq, 0);
        repeat (30) @(negedge clk);
        check(stop_done, "R7", stop_done, 1);
        pulse(1);
        check(!stop_done, "R7", stop_done, 0);
    endtask

    task automatic test_reset_abort();
        int t;
        brg_reload = 7'd20;
        pulse(2);
        pulse(0);
        wait_sig(0, 1'b1, t);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!scl_oe && !sda_oe && !stop_en, "R9", {scl_oe, sda_oe, stop_en}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(!scl_oe && !sda_oe && !stop_irq, "R9", {scl_oe, sda_oe, stop_irq}, 0);
    endtask

    initial begin
        test_reset_state();
        run_stop(7'd5, 0, 1'b0);
        run_stop(7'd0, 0, 1'b0);
        run_stop(7'd3, 37, 1'b0);
        run_stop(7'd9, 0, 1'b1);
        run_stop(7'd127, 0, 1'b0);
        run_stop(7'd1, 90, 1'b0);
        test_reset_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule